// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps addresses issued on the local (CPU-side) bus onto the PCI address space through a small set of programmable windows. Two windows can be active. Each one holds a 64-bit local base, a 64-bit PCI base and a 32-bit size word. Bit 0 of the size word switches the window on. The remaining bits form a mask, and the two's complement of that mask gives the window length.

Software programs the windows through a 32-bit register port. Each 64-bit base is reached as a low half and a high half, and a write to one half leaves the other half intact. A third size register is provided. It stores and returns its value, but it never opens a mapping.

On the lookup side, a local address enters and the block returns three results in the same cycle, with no register in the path:
- whether an enabled window covers the address;
- which window covers it;
- the translated PCI address.

When two enabled windows overlap, the lower-numbered window wins.

Top module: `outbound_xlate`

## Requirements
- R1: After reset every window register reads as zero, and no lookup address produces a hit.
- R2: Window 0 registers sit at these byte offsets: local base low 0x68, local base high 0x6C, size 0x70, PCI base low 0x74, PCI base high 0x78. Window 1 uses the same order at 0x7C, 0x80, 0x84, 0x88 and 0x8C. Every one of these registers reads back the last value written to it.
- R3: A write to one 32-bit half of a 64-bit base leaves the other half unchanged.
- R4: A window whose size word has bit 0 clear never produces a hit.
- R5: The window size is the 32-bit two's complement of the size word with bit 0 forced to zero. An enabled window hits exactly for addresses in [local base, local base + size).
- R6: When the two's complement in R5 comes out as zero, the size is taken as 0xFFFFFFFF.
- R7: On a hit, the PCI address is PCI base + (address − local base). On a miss, the hit flag is 0, the window index is 0 and the PCI address is zero.
- R8: A size register at offset 0x90 is writable and reads back its value, but it never causes a hit. The reported window index is never 2.
- R9: When both windows hit, window 0 is reported, together with its translation.
- R10: A write to any offset not listed in R2 or R8 changes no register. A read from such an offset returns zero.
- R11: A register write changes the lookup result starting after the next rising clock edge. The lookup path itself is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_addr | input | 64 | Local address to translate |
| lk_hit | output | 1 | An enabled window covers lk_addr |
| lk_win | output | 2 | Index of the window that hit |
| lk_pci_addr | output | 64 | Translated PCI address |

## Verification
The assertions check on every cycle that:
- a reported hit always comes from an enabled window and never from index 2;
- a miss drives the window index and the PCI address to zero;
- window 1 is never reported while window 0 also matches;
- a write to a low half of a local base keeps the high half.

Only the directed scenarios can show the remaining behaviour:
- the exact window edges, including the near-4 GiB case;
- the arithmetic of the translated address;
- the register offsets and what they read back;
- that unmapped offsets are ignored;
- that a write takes effect one clock later.

// File: rtl/outbound_xlate.sv
module outbound_xlate #(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 32,
  parameter int OFF_W  = 8,
  parameter int NWIN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [1:0]        lk_win,
  output logic [ADDR_W-1:0] lk_pci_addr
);
  localparam int FIRST  = 'h68;
  localparam int STRIDE = 'h14;
  localparam int SPARE  = 'h90;

  logic [ADDR_W-1:0] loc_base [NWIN];
  logic [ADDR_W-1:0] pci_base [NWIN];
  logic [REG_W-1:0]  size_w   [NWIN];
  logic [REG_W-1:0]  spare_sz;

  function automatic logic at(input logic [OFF_W-1:0] a, input int w, input int fld);
    return a == OFF_W'(FIRST + w*STRIDE + fld*4);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        loc_base[i] <= '0;
        pci_base[i] <= '0;
        size_w[i]   <= '0;
      end
      spare_sz <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NWIN; i++) begin
        if (at(reg_addr, i, 0)) loc_base[i][REG_W-1:0]      <= reg_wdata;
        if (at(reg_addr, i, 1)) loc_base[i][ADDR_W-1:REG_W] <= reg_wdata;
        if (at(reg_addr, i, 2)) size_w[i]                   <= reg_wdata;
        if (at(reg_addr, i, 3)) pci_base[i][REG_W-1:0]      <= reg_wdata;
        if (at(reg_addr, i, 4)) pci_base[i][ADDR_W-1:REG_W] <= reg_wdata;
      end
      if (reg_addr == OFF_W'(SPARE)) spare_sz <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (at(reg_addr, i, 0)) reg_rdata = loc_base[i][REG_W-1:0];
      if (at(reg_addr, i, 1)) reg_rdata = loc_base[i][ADDR_W-1:REG_W];
      if (at(reg_addr, i, 2)) reg_rdata = size_w[i];
      if (at(reg_addr, i, 3)) reg_rdata = pci_base[i][REG_W-1:0];
      if (at(reg_addr, i, 4)) reg_rdata = pci_base[i][ADDR_W-1:REG_W];
    end
    if (reg_addr == OFF_W'(SPARE)) reg_rdata = spare_sz;
  end

  logic [NWIN-1:0]   match;
  logic [ADDR_W-1:0] xl [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [REG_W-1:0]  raw_sz, win_sz;
    logic [ADDR_W-1:0] off;
    assign raw_sz   = ~(size_w[g] & ~REG_W'(1)) + REG_W'(1);
    assign win_sz   = (raw_sz == '0) ? '1 : raw_sz;
    assign off      = lk_addr - loc_base[g];
    assign match[g] = size_w[g][0] && (lk_addr >= loc_base[g]) &&
                      (off < {{(ADDR_W-REG_W){1'b0}}, win_sz});
    assign xl[g]    = pci_base[g] + off;
  end

  always_comb begin
    lk_hit      = 1'b0;
    lk_win      = '0;
    lk_pci_addr = '0;
    for (int i = NWIN-1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit      = 1'b1;
        lk_win      = 2'(i);
        lk_pci_addr = xl[i];
      end
    end
  end

  assert_hit_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_win < 2'(NWIN)) && size_w[lk_win][0]);

  assert_never_spare_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_win != 2'd2);

  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_win == 2'd0) && (lk_pci_addr == '0));

  assert_low_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_win == 2'd1) |-> !match[0]);

  assert_half_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_W'(FIRST)) |=>
      loc_base[0][ADDR_W-1:REG_W] == $past(loc_base[0][ADDR_W-1:REG_W]));
endmodule

// File: tb/tb_outbound_xlate.sv
`timescale 1ns/1ps
module tb_outbound_xlate;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] lk_addr = 0, lk_pci_addr;
  logic        lk_hit;
  logic [1:0]  lk_win;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  outbound_xlate dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1; chk(req, {32'b0, reg_rdata}, {32'b0, exp});
  endtask

  task automatic look(input string req, input logic [63:0] a, input logic h,
                      input logic [1:0] w, input logic [63:0] p);
    lk_addr = a; #1;
    chk({req, " hit"}, {63'b0, lk_hit}, {63'b0, h});
    chk({req, " win"}, {62'b0, lk_win}, {62'b0, w});
    chk({req, " pci"}, lk_pci_addr, p);
  endtask

  task automatic set_win(input int w, input logic [63:0] la, input logic [31:0] sz,
                         input logic [63:0] pa);
    logic [7:0] b = 8'(8'h68 + w*8'h14);
    wr(b, la[31:0]); wr(b+4, la[63:32]); wr(b+8, sz);
    wr(b+12, pa[31:0]); wr(b+16, pa[63:32]);
  endtask

  task automatic clear_all();
    set_win(0, 0, 0, 0); set_win(1, 0, 0, 0); wr(8'h90, 0);
  endtask

  task automatic t_reset();
    for (int o = 'h68; o <= 'h90; o += 4) rd_chk("R1 reset read", 8'(o), 0);
    look("R1 reset lookup", 64'h0, 0, 0, 0);
    look("R1 reset lookup hi", 64'hFFFF_FFFF_0000_0000, 0, 0, 0);
  endtask

  task automatic t_regs();
    for (int o = 'h68; o <= 'h8C; o += 4) wr(8'(o), 32'hA500_0000 + 32'(o));
    for (int o = 'h68; o <= 'h8C; o += 4) rd_chk("R2 readback", 8'(o), 32'hA500_0000 + 32'(o));
    clear_all();
  endtask

  task automatic t_half();
    wr(8'h68, 32'h1111_2222); wr(8'h6C, 32'h3333_4444);
    rd_chk("R3 low kept", 8'h68, 32'h1111_2222);
    wr(8'h68, 32'h5555_6666);
    rd_chk("R3 high kept", 8'h6C, 32'h3333_4444);
    wr(8'h8C, 32'hDEAD_0000); wr(8'h88, 32'h0000_BEEF);
    rd_chk("R3 pci high kept", 8'h8C, 32'hDEAD_0000);
    clear_all();
  endtask

  task automatic t_range();
    set_win(0, 64'h1_0000_0000, 32'hFFFF_0001, 64'h8000_0000);
    look("R5 base", 64'h1_0000_0000, 1, 0, 64'h8000_0000);
    look("R7 last", 64'h1_0000_FFFF, 1, 0, 64'h8000_FFFF);
    look("R5 past end", 64'h1_0001_0000, 0, 0, 0);
    look("R5 below", 64'h0_FFFF_FFFF, 0, 0, 0);
    wr(8'h70, 32'hFFFF_0000);
    look("R4 disabled", 64'h1_0000_0000, 0, 0, 0);
    wr(8'h70, 32'hFFFF_FFFF);
    look("R5 size two", 64'h1_0000_0001, 1, 0, 64'h8000_0001);
    look("R5 size two end", 64'h1_0000_0002, 0, 0, 0);
    clear_all();
  endtask

  task automatic t_zero();
    set_win(1, 64'h2_0000_0000, 32'h0000_0001, 64'h10_0000_0000);
    look("R6 near end", 64'h2_FFFF_FFFE, 1, 1, 64'h10_FFFF_FFFE);
    look("R6 end", 64'h2_FFFF_FFFF, 0, 0, 0);
    clear_all();
  endtask

  task automatic t_spare();
    wr(8'h90, 32'hFFFF_0001);
    rd_chk("R8 spare readback", 8'h90, 32'hFFFF_0001);
    look("R8 no mapping zero", 64'h0, 0, 0, 0);
    look("R8 no mapping", 64'h0000_1234, 0, 0, 0);
    clear_all();
  endtask

  task automatic t_prio();
    set_win(0, 64'h4000, 32'hFFFF_F001, 64'hA000);
    set_win(1, 64'h4000, 32'hFFFF_0001, 64'hB000_0000);
    look("R9 overlap", 64'h4010, 1, 0, 64'hA010);
    look("R9 only win1", 64'h5010, 1, 1, 64'hB000_1010);
    wr(8'h70, 32'hFFFF_F000);
    look("R9 win0 off", 64'h4010, 1, 1, 64'hB000_0010);
    clear_all();
  endtask

  task automatic t_unmapped();
    wr(8'h70, 32'h0000_00F1);
    wr(8'h94, 32'hFFFF_FFFF); wr(8'h6A, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped read", 8'h94, 0);
    rd_chk("R10 unmapped read 2", 8'h00, 0);
    rd_chk("R10 size untouched", 8'h70, 32'h0000_00F1);
    rd_chk("R10 base untouched", 8'h68, 0);
    rd_chk("R10 base hi untouched", 8'h6C, 0);
    clear_all();
  endtask

  task automatic t_timing();
    set_win(0, 64'h9000, 32'hFFFF_F000, 64'h100);
    lk_addr = 64'h9004;
    @(negedge clk); reg_wr = 1; reg_addr = 8'h70; reg_wdata = 32'hFFFF_F001;
    #1; chk("R11 before edge", {63'b0, lk_hit}, 0);
    @(negedge clk); reg_wr = 0;
    look("R11 after edge", 64'h9004, 1, 0, 64'h104);
    clear_all();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1; t_reset();
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset();
    t_regs();
    t_half();
    t_range();
    t_zero();
    t_spare();
    t_prio();
    t_unmapped();
    t_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule